// File: doc/BRIEF.md
# Global-History Agree Branch Predictor

This block predicts conditional branch directions with one table of two-bit counters, indexed only by a global history register. A counter does not predict taken or not-taken. It predicts whether the branch will follow a static bias bit that the branch instruction carries. At prediction time the fetch logic presents the bias bit. The block returns the final direction in the same cycle. It also returns the current history, which the pipeline keeps with the branch as a checkpoint.

When a branch resolves, the pipeline presents the bias bit, the actual outcome, an inversion hint and the checkpoint from prediction time. The counter that the checkpoint selects moves toward agree if the outcome matched the bias, and toward disagree if it did not. The history then shifts in the outcome XOR the hint. On a misprediction the history is rebuilt from the checkpoint, so later younger-branch state is discarded. Updates arrive in program order, one per cycle at most.

Top module: `agree_predictor`

## Requirements
- R1: After synchronous reset the history reads 0 and every counter holds weakly agree (2'b10), so the predicted direction equals the presented bias bit.
- R2: The predicted direction is the bias bit XNOR the most significant bit of the counter selected by the current history (1 = taken, MSB 1 = agree). It is combinational in the same cycle, and a write in this cycle is seen from the next cycle on.
- R3: On an update the counter at index `upd_ckpt` steps up by one when `upd_taken` equals `upd_bias`, and steps down by one otherwise.
- R4: Counters saturate at 3 and at 0.
- R5: An update without misprediction shifts the history left by one and places `upd_taken XOR upd_hint` in bit 0. The oldest bit is dropped.
- R6: An update flagged as mispredicted sets the history to `upd_ckpt` shifted left by one with `upd_taken XOR upd_hint` in bit 0.
- R7: With `upd_valid` low the history and all counters keep their values.
- R8: The table holds ENTRIES counters (default 2048) and is indexed by history alone. Training one index leaves the others unchanged, including the top index ENTRIES-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_bias | input | 1 | Bias bit of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_ckpt | output | log2(ENTRIES) | Current global history, kept with the branch as its checkpoint |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_bias | input | 1 | Bias bit of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_hint | input | 1 | Inversion hint for the history bit |
| upd_mispredict | input | 1 | Resolved branch was mispredicted; repair the history |
| upd_ckpt | input | log2(ENTRIES) | History the branch was predicted with |

## Verification
The bench builds the block at the default of 2048 entries, which gives an 11-bit history. A behavioural model tracks every counter and the history and is compared each cycle. Mispredict updates carry chosen checkpoints, so the bench can place the history on any index, including 0, 5 and 2047. This lets it train single entries through both saturation limits and then confirm that neighbouring entries stayed at their reset value. A long random phase mixes hints, biases, idle cycles and repairs.

// File: rtl/agp_pkg.sv
package agp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_WEAK_AGREE = 2'b10;
    localparam ctr_t CTR_MAX        = 2'b11;
    localparam ctr_t CTR_MIN        = 2'b00;

    typedef struct packed {
        logic valid;
        logic bias;
        logic taken;
        logic hint;
        logic mispredict;
    } upd_req_t;

    typedef struct packed {
        logic wr_en;
        logic agreed;
        logic hist_bit;
        logic repair;
    } upd_eff_t;

    function automatic ctr_t ctr_step(input ctr_t c, input logic agreed);
        ctr_t r;
        if (agreed) r = (c == CTR_MAX) ? c : c + 2'd1;
        else        r = (c == CTR_MIN) ? c : c - 2'd1;
        return r;
    endfunction

    function automatic logic final_dir(input logic bias, input ctr_t c);
        return ~(bias ^ c[1]);
    endfunction

endpackage

// File: rtl/agp_resolve.sv
module agp_resolve
    import agp_pkg::*;
(
    input  upd_req_t req,
    output upd_eff_t eff
);
    always_comb begin
        eff.wr_en    = req.valid;
        eff.agreed   = (req.taken == req.bias);
        eff.hist_bit = req.taken ^ req.hint;
        eff.repair   = req.valid & req.mispredict;
    end
endmodule

// File: rtl/agp_hist.sv
module agp_hist #(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             repair,
    input  logic             new_bit,
    input  logic [IDX_W-1:0] ckpt,
    output logic [IDX_W-1:0] hist
);
    logic [IDX_W-1:0] base;
    logic [IDX_W-1:0] hist_q;

    always_comb base = repair ? ckpt : hist_q;

    always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (shift_en) hist_q <= (base << 1) | IDX_W'(new_bit);
    end

    assign hist = hist_q;
endmodule

// File: rtl/agp_pht.sv
module agp_pht
    import agp_pkg::*;
#(
    parameter int ENTRIES = 2048,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_agreed
);
    ctr_t tbl [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) tbl[i] <= CTR_WEAK_AGREE;
        end else if (wr_en) begin
            tbl[wr_idx] <= ctr_step(tbl[wr_idx], wr_agreed);
        end
    end

    assign rd_ctr = tbl[rd_idx];
endmodule

// File: rtl/agree_predictor.sv
module agree_predictor
    import agp_pkg::*;
#(
    parameter int ENTRIES = 2048,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pred_bias,
    output logic             pred_taken,
    output logic [IDX_W-1:0] pred_ckpt,
    input  logic             upd_valid,
    input  logic             upd_bias,
    input  logic             upd_taken,
    input  logic             upd_hint,
    input  logic             upd_mispredict,
    input  logic [IDX_W-1:0] upd_ckpt
);
    upd_req_t         req;
    upd_eff_t         eff;
    ctr_t             rd_ctr;
    logic [IDX_W-1:0] hist;

    always_comb begin
        req.valid      = upd_valid;
        req.bias       = upd_bias;
        req.taken      = upd_taken;
        req.hint       = upd_hint;
        req.mispredict = upd_mispredict;
    end

    agp_resolve u_resolve (
        .req (req),
        .eff (eff)
    );

    agp_hist #(.IDX_W(IDX_W)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (eff.wr_en),
        .repair   (eff.repair),
        .new_bit  (eff.hist_bit),
        .ckpt     (upd_ckpt),
        .hist     (hist)
    );

    agp_pht #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pht (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (hist),
        .rd_ctr    (rd_ctr),
        .wr_en     (eff.wr_en),
        .wr_idx    (upd_ckpt),
        .wr_agreed (eff.agreed)
    );

    assign pred_taken = final_dir(pred_bias, rd_ctr);
    assign pred_ckpt  = hist;
endmodule

// File: rtl/agree_predictor_chk.sv
module agree_predictor_chk #(
    parameter int IDX_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             pred_bias,
    input logic             pred_taken,
    input logic [IDX_W-1:0] pred_ckpt,
    input logic             upd_valid,
    input logic             upd_bias,
    input logic             upd_taken,
    input logic             upd_hint,
    input logic             upd_mispredict,
    input logic [IDX_W-1:0] upd_ckpt
);
    a_r1_reset_follows_bias: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pred_taken == pred_bias && pred_ckpt == '0));

    a_r5_hist_shift: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_mispredict) |=>
        pred_ckpt == (($past(pred_ckpt) << 1) | IDX_W'($past(upd_taken ^ upd_hint))));

    a_r6_hist_repair: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_mispredict) |=>
        pred_ckpt == (($past(upd_ckpt) << 1) | IDX_W'($past(upd_taken ^ upd_hint))));

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(pred_ckpt));

    a_r2_bias_flip: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!upd_valid) && pred_bias != $past(pred_bias))
        |-> pred_taken != $past(pred_taken));
endmodule

bind agree_predictor agree_predictor_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .pred_bias(pred_bias), .pred_taken(pred_taken),
    .pred_ckpt(pred_ckpt), .upd_valid(upd_valid), .upd_bias(upd_bias),
    .upd_taken(upd_taken), .upd_hint(upd_hint), .upd_mispredict(upd_mispredict),
    .upd_ckpt(upd_ckpt)
);

// File: tb/agree_predictor_test.sv
`timescale 1ns/1ps
module agree_predictor_test;
    localparam int N  = 2048;
    localparam int W  = 11;
    localparam int MK = N - 1;

    logic         clk = 0;
    logic         rst = 1;
    logic         pred_bias = 0;
    logic         pred_taken;
    logic [W-1:0] pred_ckpt;
    logic         upd_valid = 0, upd_bias = 0, upd_taken = 0, upd_hint = 0, upd_mispredict = 0;
    logic [W-1:0] upd_ckpt = '0;

    int checks = 0;
    int fails  = 0;
    int mctr [N];
    int mhist = 0;

    always #2 clk = ~clk;

    agree_predictor uut (
        .clk(clk), .rst(rst), .pred_bias(pred_bias), .pred_taken(pred_taken),
        .pred_ckpt(pred_ckpt), .upd_valid(upd_valid), .upd_bias(upd_bias),
        .upd_taken(upd_taken), .upd_hint(upd_hint), .upd_mispredict(upd_mispredict),
        .upd_ckpt(upd_ckpt)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int mdir(input int b);
        return (b == ((mctr[mhist] >= 2) ? 1 : 0)) ? 1 : 0;
    endfunction

    // one clock: drive, compare prediction, clock, update model, compare history
    task automatic step(input int b, input int v, input int ub, input int t,
                        input int h, input int m, input int ck, input string htag);
        @(negedge clk);
        pred_bias = b[0]; upd_valid = v[0]; upd_bias = ub[0]; upd_taken = t[0];
        upd_hint = h[0]; upd_mispredict = m[0]; upd_ckpt = ck[W-1:0];
        #1;
        check(pred_taken == mdir(b), "R2 direction", pred_taken, mdir(b));
        @(posedge clk);
        if (v != 0) begin
            if (t == ub) mctr[ck] = (mctr[ck] == 3) ? 3 : mctr[ck] + 1;
            else         mctr[ck] = (mctr[ck] == 0) ? 0 : mctr[ck] - 1;
            mhist = ((((m != 0) ? ck : mhist) << 1) | (t ^ h)) & MK;
        end
        #1;
        check(int'(pred_ckpt) == mhist, htag, pred_ckpt, mhist);
    endtask

    task automatic seek(input int idx);
        step(0, 1, 0, idx & 1, 0, 1, (idx >> 1), "R6 seek");
    endtask

    task automatic train(input int idx, input int agree, input int n);
        for (int k = 0; k < n; k++) step(0, 1, 1, agree, 0, 0, idx, "R5 train");
    endtask

    task automatic peek(input int b, input int exp, input string tag);
        @(negedge clk);
        pred_bias = b[0]; upd_valid = 0;
        #1;
        check(pred_taken == exp[0], tag, pred_taken, exp);
    endtask

    initial begin
        #(200000 * 4);
        fails++; checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) mctr[i] = 2;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        check(pred_ckpt == '0, "R1 history", pred_ckpt, 0);
        peek(0, 0, "R1 bias0");
        peek(1, 1, "R1 bias1");

        // R5: outcome xor hint shifted in
        step(0, 1, 1, 1, 0, 0, 0, "R5 shift");
        step(0, 1, 1, 1, 1, 0, 1, "R5 shift");
        step(0, 1, 1, 0, 1, 0, 2, "R5 shift");
        check(pred_ckpt == 11'd5, "R5 value", pred_ckpt, 5);
        step(1, 0, 1, 1, 1, 1, 7, "R7 idle");
        check(pred_ckpt == 11'd5, "R7 value", pred_ckpt, 5);

        // R3/R4 at index 5: down to 0 and back
        train(5, 0, 3);
        seek(5);
        peek(1, 0, "R3 disagree");
        peek(0, 1, "R3 disagree bias0");
        train(5, 1, 1);
        seek(5);
        peek(1, 0, "R4 low saturation");
        train(5, 1, 1);
        seek(5);
        peek(1, 1, "R3 agree again");
        train(5, 1, 4);
        train(5, 0, 1);
        seek(5);
        peek(1, 1, "R4 high saturation");

        // R8: neighbour untouched, top index
        seek(4);
        peek(0, 0, "R8 neighbour");
        train(MK, 0, 2);
        seek(MK);
        check(pred_ckpt == 11'h7ff, "R6 top index", pred_ckpt, MK);
        peek(0, 1, "R8 top index");
        seek(MK - 1);
        peek(1, 1, "R8 below top");

        // random mix, model compared every clock
        for (int i = 0; i < 4000; i++) begin
            int v, m, ck;
            v  = ($urandom % 4 != 0) ? 1 : 0;
            m  = ($urandom % 5 == 0) ? 1 : 0;
            ck = ($urandom % 8 == 0) ? int'($urandom % N) : mhist;
            step($urandom % 2, v, $urandom % 2, $urandom % 2, $urandom % 2, m, ck,
                 (v == 0) ? "R7 random" : ((m != 0) ? "R6 random" : "R5 random"));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule